// File: doc/BRIEF.md
# Clock Window Watchdog Monitor

This block supervises the clocks that feed a chip's analog and filtering logic. It runs from a free-running reference clock that is independent of the system clock. It watches two derived clocks: channel 0 is the modulator/analog clock and channel 1 is the digital filter clock. For each one it counts synchronized rising edges over a fixed window of reference cycles. It then compares the count against a programmable lower limit and a programmable upper limit, each with hysteresis. A clock that falls outside its window sets a per-channel status bit and raises a sticky non-maskable interrupt request, which software clears by writing 1.

The block also watches the system clock for loss. If no system-clock edge arrives within a programmable number of reference cycles, the block declares the clock lost. It then forces off the low-side driver, high-side driver and LIN transceiver enables without any software action. The requested enables pass through again once system-clock edges return.

Top module: `clkwin_monitor`

## Requirements
- R1: While reset is asserted and directly after it, every status bit, the interrupt request, the loss flag and all three driver enables are 0.
- R2: Each enabled channel counts synchronized rising edges of its clock over windows of WIN_CYC reference cycles. The first window starts at reset release. Status is updated only at the reference edge that closes a window, so nothing changes before the first full window has ended.
- R3: The low flag of a channel sets when the window count is below the lower limit. Once set, it clears only when the count is at least the lower limit plus the hysteresis.
- R4: The high flag of a channel sets when the window count is above the upper limit. Once set, it clears only when the count plus the hysteresis is at most the upper limit.
- R5: Status bit `oor_o[i]` is 1 when channel i has its low or high flag set. Bit 0 belongs to the modulator clock and bit 1 to the filter clock. The two channels are evaluated independently.
- R6: While `ch_en_i[i]` is 0, `oor_o[i]` is 0 and channel i raises no interrupt. The first window that closes after the channel is enabled again is discarded.
- R7: `nmi_o` sets at any window end where an enabled channel is out of range. It stays set until a cycle with `nmi_clr_i` = 1 and no new event. A new event in the same cycle as a clear wins.
- R8: `sys_lost_o` becomes 1 once no synchronized system-clock rising edge has been seen for `loss_limit_i` reference cycles (a limit of at least 1 is assumed). It returns to 0 on the next such edge.
- R9: `ls_en_o`, `hs_en_o` and `lin_en_o` follow `ls_en_i`, `hs_en_i` and `lin_en_i` one cycle later. They are forced to 0 in the cycle after `sys_lost_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_clk_i | input | NCH | Monitored clocks (bit 0 modulator, bit 1 filter), asynchronous |
| sys_clk_i | input | 1 | System clock under loss watch, asynchronous |
| ch_en_i | input | NCH | Per-channel enable |
| lo_lim_i | input | NCH x CW | Lower edge-count limit per channel |
| hi_lim_i | input | NCH x CW | Upper edge-count limit per channel |
| hyst_i | input | NCH x CW | Hysteresis margin per channel |
| loss_limit_i | input | LOSS_W | Reference cycles without a system-clock edge before loss |
| nmi_clr_i | input | 1 | Write-1 clear of the pending interrupt |
| ls_en_i | input | 1 | Requested low-side driver enable |
| hs_en_i | input | 1 | Requested high-side driver enable |
| lin_en_i | input | 1 | Requested LIN transceiver enable |
| oor_o | output | NCH | Per-channel out-of-range status |
| nmi_o | output | 1 | Pending clock watchdog interrupt request |
| sys_lost_o | output | 1 | System clock loss flag |
| ls_en_o | output | 1 | Gated low-side driver enable |
| hs_en_o | output | 1 | Gated high-side driver enable |
| lin_en_o | output | 1 | Gated LIN transceiver enable |

## Verification
Status bits and the interrupt request are due right after the reference edge that closes a window: the WIN_CYC-th, 2·WIN_CYC-th, ... edge after reset release. The bench counts edges since reset, changes limits and clock rates just after a window end, and samples on the falling edge that follows the next window end. After a clock-rate change it lets one transient window pass first. The test clock periods divide the window, so every clean window holds an exact count and the hysteresis boundaries can be checked at equality. The loss flag is due a few cycles after the limit expires, because of the synchronizer. The bench therefore samples it with a margin of ten cycles past the limit and samples the gated enables one cycle after that.

// File: rtl/clkwin_pkg.sv
// Package: shared types and helpers for the clock window watchdog monitor.
// Assumes counts are unsigned and fit the widths chosen by the instantiating module.
package clkwin_pkg;

    // Channel index assignment: fixed by the status bit layout.
    localparam int CH_MOD  = 0;
    localparam int CH_FILT = 1;

    // Pair of limit flags kept per channel.
    typedef struct packed {
        logic lo;
        logic hi;
    } lim_flags_t;

    // Index of the gated driver enables inside the internal enable vector.
    typedef enum logic [1:0] {
        DRV_LS  = 2'd0,
        DRV_HS  = 2'd1,
        DRV_LIN = 2'd2
    } drv_idx_e;

    localparam int NUM_DRV = 3;

endpackage

// File: rtl/clkwin_sync_edge.sv
// Module: clkwin_sync_edge
// Brings an asynchronous clock-like signal into the reference domain through a
// STAGES-deep synchronizer and flags each rising edge for one reference cycle.
// Assumes the input stays high and low for at least one reference cycle each.
module clkwin_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchronizer chain plus one history flop for edge detection.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Rising edge seen at the synchronizer output.
    assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/clkwin_window_timer.sv
// Module: clkwin_window_timer
// Free-running counter of reference cycles that pulses win_end_o on the last
// cycle of every WIN_CYC-cycle window. The first window starts at reset release.
module clkwin_window_timer #(
    parameter int WIN_CYC = 256,
    localparam int WIN_W  = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1
) (
    input  logic clk_ref,
    input  logic rst_n,
    output logic win_end_o
);

    localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_CYC - 1);

    logic [WIN_W-1:0] tick_q;

    // Window position counter, wraps after the last cycle.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (tick_q == LAST) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    // Last cycle of the current window.
    assign win_end_o = (tick_q == LAST);

endmodule

// File: rtl/clkwin_channel.sv
// Module: clkwin_channel
// One frequency window channel: counts synchronized rising edges per window and,
// at each window end, compares the count with lower and upper limits that each
// carry hysteresis. A disabled channel reports in range, and the first window
// after it is enabled again is discarded. The edge arriving in the window-end
// cycle belongs to the closing window.
module clkwin_channel #(
    parameter int CW = 9
) (
    input  logic          clk_ref,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          rise_i,
    input  logic          win_end_i,
    input  logic [CW-1:0] lo_lim_i,
    input  logic [CW-1:0] hi_lim_i,
    input  logic [CW-1:0] hyst_i,
    output logic          oor_o,
    output logic          evt_o
);

    import clkwin_pkg::*;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] meas;
    logic [CW:0]   meas_w;
    logic [CW:0]   lo_rel;
    logic [CW:0]   hi_rel;
    logic          armed_q;
    logic          judge;
    lim_flags_t    flg_q;
    lim_flags_t    flg_nxt;

    // Count of the closing window, saturating at the counter width.
    always_comb begin
        if (rise_i && (cnt_q != '1)) begin
            meas = cnt_q + 1'b1;
        end else begin
            meas = cnt_q;
        end
    end

    assign meas_w = {1'b0, meas};
    assign lo_rel = {1'b0, lo_lim_i} + {1'b0, hyst_i};
    assign hi_rel = meas_w + {1'b0, hyst_i};
    assign judge  = win_end_i & en_i & armed_q;

    // Hysteresis decision for both limits at a window end.
    always_comb begin
        flg_nxt = flg_q;
        if (judge) begin
            if (flg_q.lo) begin
                flg_nxt.lo = (meas_w < lo_rel);
            end else begin
                flg_nxt.lo = (meas < lo_lim_i);
            end
            if (flg_q.hi) begin
                flg_nxt.hi = (hi_rel > {1'b0, hi_lim_i});
            end else begin
                flg_nxt.hi = (meas > hi_lim_i);
            end
        end
    end

    // Edge counter, restarted at each window end and held clear while disabled.
    always_ff @(posedge clk_ref) begin
        if (!rst_n || !en_i || win_end_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= meas;
        end
    end

    // Arming: a channel only judges windows it has fully observed.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
        end else if (!en_i) begin
            armed_q <= 1'b0;
        end else if (win_end_i) begin
            armed_q <= 1'b1;
        end
    end

    // Limit flags, forced in range while the channel is disabled.
    always_ff @(posedge clk_ref) begin
        if (!rst_n || !en_i) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_nxt;
        end
    end

    assign oor_o = flg_q.lo | flg_q.hi;
    assign evt_o = judge & (flg_nxt.lo | flg_nxt.hi);

endmodule

// File: rtl/clkwin_loss_det.sv
// Module: clkwin_loss_det
// Declares the system clock lost when no synchronized rising edge has been seen
// for limit_i reference cycles; the next edge clears the condition.
// Assumes limit_i is at least 1 (a limit of 0 reports loss permanently).
module clkwin_loss_det #(
    parameter int LOSS_W = 6
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic [LOSS_W-1:0] limit_i,
    output logic              lost_o
);

    logic [LOSS_W-1:0] idle_q;
    logic [LOSS_W-1:0] idle_nxt;
    logic              lost_q;

    // Idle cycle count since the last edge, saturating.
    always_comb begin
        if (rise_i) begin
            idle_nxt = '0;
        end else if (idle_q != '1) begin
            idle_nxt = idle_q + 1'b1;
        end else begin
            idle_nxt = idle_q;
        end
    end

    // Idle counter and registered loss decision.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            idle_q <= '0;
            lost_q <= 1'b0;
        end else begin
            idle_q <= idle_nxt;
            lost_q <= (idle_nxt >= limit_i);
        end
    end

    assign lost_o = lost_q;

endmodule

// File: rtl/clkwin_monitor.sv
// Module: clkwin_monitor (top)
// Clock window watchdog: NCH frequency window channels sharing one window timer,
// a sticky interrupt request, and a system clock loss detector that gates the
// power-stage and LIN enables. All logic runs on clk_ref; mon_clk_i and
// sys_clk_i are asynchronous and slower than half the reference rate.
module clkwin_monitor #(
    parameter int WIN_CYC  = 256,
    parameter int NCH      = 2,
    parameter int LOSS_W   = 6,
    parameter int SYNC_STG = 2,
    localparam int CW      = $clog2(WIN_CYC + 1)
) (
    input  logic                   clk_ref,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         mon_clk_i,
    input  logic                   sys_clk_i,
    input  logic [NCH-1:0]         ch_en_i,
    input  logic [NCH-1:0][CW-1:0] lo_lim_i,
    input  logic [NCH-1:0][CW-1:0] hi_lim_i,
    input  logic [NCH-1:0][CW-1:0] hyst_i,
    input  logic [LOSS_W-1:0]      loss_limit_i,
    input  logic                   nmi_clr_i,
    input  logic                   ls_en_i,
    input  logic                   hs_en_i,
    input  logic                   lin_en_i,
    output logic [NCH-1:0]         oor_o,
    output logic                   nmi_o,
    output logic                   sys_lost_o,
    output logic                   ls_en_o,
    output logic                   hs_en_o,
    output logic                   lin_en_o
);

    import clkwin_pkg::*;

    logic                win_end;
    logic [NCH-1:0]      mon_rise;
    logic [NCH-1:0]      ch_evt;
    logic                sys_rise;
    logic                nmi_q;
    logic [NUM_DRV-1:0]  drv_req;
    logic [NUM_DRV-1:0]  drv_q;

    // Shared measurement window.
    clkwin_window_timer #(.WIN_CYC(WIN_CYC)) u_win (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .win_end_o (win_end)
    );

    // One synchronizer and window checker per monitored clock.
    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        clkwin_sync_edge #(.STAGES(SYNC_STG)) u_sync (
            .clk_ref (clk_ref),
            .rst_n   (rst_n),
            .async_i (mon_clk_i[gi]),
            .rise_o  (mon_rise[gi])
        );

        clkwin_channel #(.CW(CW)) u_chan (
            .clk_ref   (clk_ref),
            .rst_n     (rst_n),
            .en_i      (ch_en_i[gi]),
            .rise_i    (mon_rise[gi]),
            .win_end_i (win_end),
            .lo_lim_i  (lo_lim_i[gi]),
            .hi_lim_i  (hi_lim_i[gi]),
            .hyst_i    (hyst_i[gi]),
            .oor_o     (oor_o[gi]),
            .evt_o     (ch_evt[gi])
        );
    end

    // System clock path: synchronizer then idle timeout.
    clkwin_sync_edge #(.STAGES(SYNC_STG)) u_sys_sync (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .async_i (sys_clk_i),
        .rise_o  (sys_rise)
    );

    clkwin_loss_det #(.LOSS_W(LOSS_W)) u_loss (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .rise_i  (sys_rise),
        .limit_i (loss_limit_i),
        .lost_o  (sys_lost_o)
    );

    // Sticky interrupt request: a new event outranks a clear in the same cycle.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            nmi_q <= 1'b0;
        end else begin
            nmi_q <= (nmi_q & ~nmi_clr_i) | (|ch_evt);
        end
    end

    assign nmi_o = nmi_q;

    // Collect requested enables in driver order.
    always_comb begin
        drv_req          = '0;
        drv_req[DRV_LS]  = ls_en_i;
        drv_req[DRV_HS]  = hs_en_i;
        drv_req[DRV_LIN] = lin_en_i;
    end

    // Registered enables, forced off while the system clock is lost.
    for (genvar gd = 0; gd < NUM_DRV; gd++) begin : g_drv
        always_ff @(posedge clk_ref) begin
            if (!rst_n) begin
                drv_q[gd] <= 1'b0;
            end else begin
                drv_q[gd] <= drv_req[gd] & ~sys_lost_o;
            end
        end
    end

    assign ls_en_o  = drv_q[DRV_LS];
    assign hs_en_o  = drv_q[DRV_HS];
    assign lin_en_o = drv_q[DRV_LIN];

endmodule

// File: rtl/clkwin_monitor_chk.sv
// Module: clkwin_monitor_chk
// Property checker bound into clkwin_monitor. Observes ports plus the window-end
// pulse and the synchronized system-clock edge.
module clkwin_monitor_chk #(
    parameter int NCH    = 2,
    parameter int LOSS_W = 6
) (
    input logic              clk_ref,
    input logic              rst_n,
    input logic [NCH-1:0]    ch_en_i,
    input logic              nmi_clr_i,
    input logic [LOSS_W-1:0] loss_limit_i,
    input logic [NCH-1:0]    oor_o,
    input logic              nmi_o,
    input logic              sys_lost_o,
    input logic              ls_en_o,
    input logic              hs_en_o,
    input logic              lin_en_o,
    input logic              win_end,
    input logic              sys_rise
);

    // R2: status of channels that stayed enabled moves only after a window end.
    assert_status_at_window_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !$past(win_end) |-> ((oor_o & $past(ch_en_i)) == ($past(oor_o) & $past(ch_en_i))));

    // R6: a channel disabled at the previous edge reports in range.
    assert_disabled_inrange_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        1'b1 |-> ((oor_o & ~$past(ch_en_i)) == '0));

    // R7: pending request survives until cleared.
    assert_nmi_sticky_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($past(nmi_o) && !$past(nmi_clr_i)) |-> nmi_o);

    // R7: the request only rises at a window end.
    assert_nmi_rise_window_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(nmi_o) |-> $past(win_end));

    // R8: a system-clock edge clears the loss flag.
    assert_edge_clears_loss_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($past(sys_rise) && ($past(loss_limit_i) != '0)) |-> !sys_lost_o);

    // R9: one cycle after loss, every driver enable is off.
    assert_loss_gates_drivers_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $past(sys_lost_o) |-> (!ls_en_o && !hs_en_o && !lin_en_o));

endmodule

bind clkwin_monitor clkwin_monitor_chk #(.NCH(NCH), .LOSS_W(LOSS_W)) u_chk (
    .clk_ref      (clk_ref),
    .rst_n        (rst_n),
    .ch_en_i      (ch_en_i),
    .nmi_clr_i    (nmi_clr_i),
    .loss_limit_i (loss_limit_i),
    .oor_o        (oor_o),
    .nmi_o        (nmi_o),
    .sys_lost_o   (sys_lost_o),
    .ls_en_o      (ls_en_o),
    .hs_en_o      (hs_en_o),
    .lin_en_o     (lin_en_o),
    .win_end      (win_end),
    .sys_rise     (sys_rise)
);

// File: tb/clkwin_monitor_tb_top.sv
`timescale 1ns/1ps
// Directed bench for clkwin_monitor: one task per scenario, each checking its results.
module clkwin_monitor_tb_top;

    localparam int WIN = 256;
    localparam int NCH = 2;
    localparam int LW  = 6;
    localparam int CW  = $clog2(WIN + 1);
    localparam int LIM = 8;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NCH-1:0]         mon_clk = '0;
    logic                   sys_clk = 1'b0;
    logic [NCH-1:0]         ch_en = '1;
    logic [NCH-1:0][CW-1:0] lo_lim;
    logic [NCH-1:0][CW-1:0] hi_lim;
    logic [NCH-1:0][CW-1:0] hyst;
    logic [LW-1:0]          loss_lim = LW'(LIM);
    logic                   nmi_clr = 1'b0;
    logic                   ls_req = 1'b1;
    logic                   hs_req = 1'b1;
    logic                   lin_req = 1'b1;
    logic [NCH-1:0]         oor;
    logic                   nmi;
    logic                   lost;
    logic                   ls_en;
    logic                   hs_en;
    logic                   lin_en;

    int checks = 0;
    int errors = 0;
    int tick = 0;
    int half0 = 8;
    int half1 = 4;
    int hsys = 2;
    int c0 = 0;
    int c1 = 0;
    int cs = 0;

    always #10 clk = ~clk;

    clkwin_monitor #(.WIN_CYC(WIN), .NCH(NCH), .LOSS_W(LW)) dut_i (
        .clk_ref      (clk),
        .rst_n        (rst_n),
        .mon_clk_i    (mon_clk),
        .sys_clk_i    (sys_clk),
        .ch_en_i      (ch_en),
        .lo_lim_i     (lo_lim),
        .hi_lim_i     (hi_lim),
        .hyst_i       (hyst),
        .loss_limit_i (loss_lim),
        .nmi_clr_i    (nmi_clr),
        .ls_en_i      (ls_req),
        .hs_en_i      (hs_req),
        .lin_en_i     (lin_req),
        .oor_o        (oor),
        .nmi_o        (nmi),
        .sys_lost_o   (lost),
        .ls_en_o      (ls_en),
        .hs_en_o      (hs_en),
        .lin_en_o     (lin_en)
    );

    // Reference edges since reset release.
    always @(posedge clk) if (rst_n) tick <= tick + 1;

    // Test clock generators, stepped on the falling reference edge.
    always @(negedge clk) begin
        if (half0 > 0) begin
            if (c0 >= half0 - 1) begin mon_clk[0] <= ~mon_clk[0]; c0 = 0; end
            else c0 = c0 + 1;
        end
        if (half1 > 0) begin
            if (c1 >= half1 - 1) begin mon_clk[1] <= ~mon_clk[1]; c1 = 0; end
            else c1 = c1 + 1;
        end
        if (hsys > 0) begin
            if (cs >= hsys - 1) begin sys_clk <= ~sys_clk; cs = 0; end
            else cs = cs + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        check(act == exp, req, what, act, exp);
    endtask

    // Advance to the falling edge right after the next window end.
    task automatic next_window();
        @(negedge clk);
        while (tick % WIN != 0) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk_eq("R1", "oor in reset", int'(oor), 0);
        chk_eq("R1", "nmi in reset", int'(nmi), 0);
        chk_eq("R1", "lost in reset", int'(lost), 0);
        chk_eq("R1", "enables in reset", int'({ls_en, hs_en, lin_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1", "oor after reset", int'(oor), 0);
        chk_eq("R1", "nmi after reset", int'(nmi), 0);
    endtask

    // ch0 count 16 below lower limit 20; ch1 count 32 inside [20,40].
    task automatic t_first_window();
        while (tick % WIN != WIN - 1) @(negedge clk);
        chk_eq("R2", "oor before first window end", int'(oor), 0);
        chk_eq("R2", "nmi before first window end", int'(nmi), 0);
        @(negedge clk);
        chk_eq("R2", "ch0 flagged at first window end", int'(oor[0]), 1);
        chk_eq("R5", "ch1 in range", int'(oor[1]), 0);
        chk_eq("R7", "nmi raised", int'(nmi), 1);
    endtask

    task automatic t_nmi_clear();
        repeat (3) @(negedge clk);
        nmi_clr = 1'b1;
        @(negedge clk);
        nmi_clr = 1'b0;
        chk_eq("R7", "nmi cleared by write", int'(nmi), 0);
        next_window();
        chk_eq("R7", "nmi set again by persisting fault", int'(nmi), 1);
        while (tick % WIN != WIN - 1) @(negedge clk);
        nmi_clr = 1'b1;
        @(negedge clk);
        nmi_clr = 1'b0;
        chk_eq("R7", "event wins over clear", int'(nmi), 1);
    endtask

    // ch0 count stays 16; lower limit moves around it with hysteresis 8.
    task automatic t_low_hyst();
        lo_lim[0] = CW'(12);
        next_window();
        chk_eq("R3", "low flag held inside hysteresis", int'(oor[0]), 1);
        lo_lim[0] = CW'(8);
        next_window();
        chk_eq("R3", "low flag clears at lo+hyst", int'(oor[0]), 0);
        lo_lim[0] = CW'(17);
        next_window();
        chk_eq("R3", "low flag sets below limit", int'(oor[0]), 1);
        lo_lim[0] = CW'(8);
        next_window();
        chk_eq("R3", "low flag clears again", int'(oor[0]), 0);
    endtask

    // ch0 count 64; upper limit moves around it with hysteresis 8.
    task automatic t_high_hyst();
        half0 = 2;
        hi_lim[0] = CW'(64);
        next_window();
        next_window();
        chk_eq("R4", "count equal to upper limit is in range", int'(oor[0]), 0);
        hi_lim[0] = CW'(63);
        next_window();
        chk_eq("R4", "high flag sets above limit", int'(oor[0]), 1);
        hi_lim[0] = CW'(70);
        next_window();
        chk_eq("R4", "high flag held inside hysteresis", int'(oor[0]), 1);
        hi_lim[0] = CW'(72);
        next_window();
        chk_eq("R4", "high flag clears at hi-hyst", int'(oor[0]), 0);
        chk_eq("R5", "ch1 unaffected", int'(oor[1]), 0);
    endtask

    // ch1 slowed to count 8 (below 20) while disabled, then enabled again.
    task automatic t_disable();
        repeat (2) @(negedge clk);
        nmi_clr = 1'b1;
        @(negedge clk);
        nmi_clr = 1'b0;
        half1 = 16;
        ch_en[1] = 1'b0;
        next_window();
        next_window();
        chk_eq("R6", "disabled channel in range", int'(oor[1]), 0);
        chk_eq("R6", "disabled channel raises no nmi", int'(nmi), 0);
        ch_en[1] = 1'b1;
        next_window();
        chk_eq("R6", "first window after enable discarded", int'(oor[1]), 0);
        chk_eq("R6", "no nmi from discarded window", int'(nmi), 0);
        next_window();
        chk_eq("R6", "fault reported after full window", int'(oor[1]), 1);
        chk_eq("R5", "ch0 stays in range", int'(oor[0]), 0);
        chk_eq("R7", "nmi from ch1", int'(nmi), 1);
    endtask

    task automatic t_loss();
        @(negedge clk);
        chk_eq("R8", "no loss while running", int'(lost), 0);
        chk_eq("R9", "enables pass while running", int'({ls_en, hs_en, lin_en}), 7);
        hsys = 0;
        repeat (LIM + 10) @(negedge clk);
        chk_eq("R8", "loss declared", int'(lost), 1);
        @(negedge clk);
        chk_eq("R9", "enables forced off", int'({ls_en, hs_en, lin_en}), 0);
        hsys = 2;
        repeat (12) @(negedge clk);
        chk_eq("R8", "loss clears on edges", int'(lost), 0);
        chk_eq("R9", "enables restored", int'({ls_en, hs_en, lin_en}), 7);
        ls_req = 1'b0;
        repeat (2) @(negedge clk);
        chk_eq("R9", "low-side follows request", int'(ls_en), 0);
        chk_eq("R9", "high-side unaffected", int'(hs_en), 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin
            lo_lim[i] = CW'(20);
            hi_lim[i] = CW'(40);
            hyst[i]   = CW'(8);
        end
        t_reset();
        t_first_window();
        t_nmi_clear();
        t_low_hyst();
        t_high_hyst();
        t_disable();
        t_loss();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule